// File: doc/BRIEF.md
# Speculative Store Buffer with Load Forwarding

This block holds the data of executed but uncommitted stores, so that memory is not changed until a store retires. When a store executes, it takes a free slot. The slot keeps the word address, the data word and the store's reorder-buffer tag, and it starts out speculative. An in-order commit signal names a store by its tag and turns that slot non-speculative. An abort names the first squashed tag and removes every speculative store at or after that point. Committed stores leave for the data cache one per cycle, oldest first, through a ready/valid drain port. A slot becomes free in the cycle the cache accepts its write.

Loads look up the buffer in the same cycle as they are presented. Only stores at the same address that are strictly older than the load take part. Among those, the youngest one supplies the word, and it takes priority over the cache data that the load brings along. Age is decided on reorder-buffer tags that carry a wrap bit above the index. Slots are allocated lowest-index-first, so slot position says nothing about age.

Top module: `spec_store_buf`

## Requirements
- R1: After reset every slot is empty: `st_ready` is 1, `dr_valid` is 0 and `ld_hit` is 0.
- R2: A store presented with `st_valid` and `st_ready` both high becomes valid and speculative at the next clock edge. From the next cycle on, a younger load to its address forwards its data. A speculative store never appears on the drain port.
- R3: `st_ready` is 0 exactly when every slot is valid. A store presented while `st_ready` is 0 is dropped and never becomes visible to loads.
- R4: `cm_valid` with `cm_tag` equal to a speculative slot's tag makes that slot non-speculative at the next edge. It can then drain once it is the oldest valid slot.
- R5: `ab_valid` with `ab_tag` invalidates, at the next edge, every speculative slot whose tag is equal to or younger than `ab_tag`. Committed slots and older speculative slots are kept.
- R6: `dr_valid` is 1 exactly when the oldest valid slot is committed. `dr_addr` and `dr_data` then show that slot. The slot is freed at the edge where `dr_valid` and `dr_ready` are both 1. So stores drain one per cycle, in tag order.
- R7: `ld_hit` is 1 when `ld_valid` is 1 and some valid slot has an address equal to `ld_addr` and a tag strictly older than `ld_tag`. If several slots qualify, the youngest of them supplies the data. This is combinational in the same cycle.
- R8: `ld_data` equals the forwarded buffer word when `ld_hit` is 1, and `ld_cache_data` otherwise.
- R9: Tag bit ROB_IDX_W is the wrap bit. When the wrap bits are equal, the smaller index is older. When they differ, the larger index is older.
- R10: A committed slot still forwards to younger loads until its drain is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Store execute request |
| st_ready | output | 1 | A free slot exists |
| st_addr | input | ADDR_W | Store word address |
| st_data | input | DATA_W | Store data |
| st_tag | input | ROB_IDX_W+1 | Store reorder-buffer tag with wrap bit |
| cm_valid | input | 1 | Commit request |
| cm_tag | input | ROB_IDX_W+1 | Tag of the committing store |
| ab_valid | input | 1 | Abort request |
| ab_tag | input | ROB_IDX_W+1 | First squashed tag |
| dr_valid | output | 1 | A committed store is offered to the cache |
| dr_ready | input | 1 | Cache accepts the offered store |
| dr_addr | output | ADDR_W | Drain address |
| dr_data | output | DATA_W | Drain data |
| ld_valid | input | 1 | Load lookup request |
| ld_addr | input | ADDR_W | Load word address |
| ld_tag | input | ROB_IDX_W+1 | Load reorder-buffer tag |
| ld_cache_data | input | DATA_W | Word read from the cache for this load |
| ld_hit | output | 1 | Buffer supplies the load |
| ld_data | output | DATA_W | Final load data |

## Verification
A wrong slot state shows up on the ports within one cycle. A lost speculative bit makes `dr_valid` rise too early or stay low. A store that survives a squash changes `ld_hit` and `ld_data` for the next younger load to its address. Wrong age ordering shows up in two places: the wrong word is forwarded when several stores share an address, and committed stores leave in the wrong order across a tag wrap. The bench compares every output against a slot-level model in every cycle. It also drives directed cases for a full buffer, an abort with committed survivors and a wrap of the tag index.

// File: rtl/ssb_pkg.sv
package ssb_pkg;

    localparam int unsigned DEF_ENTRIES   = 4;
    localparam int unsigned DEF_ADDR_W    = 16;
    localparam int unsigned DEF_DATA_W    = 32;
    localparam int unsigned DEF_ROB_IDX_W = 4;
    localparam int unsigned MAX_IDX_W     = 16;
    localparam int unsigned EXT_W         = MAX_IDX_W + 1;

    typedef enum logic [2:0] {
        SLOT_HOLD,
        SLOT_FILL,
        SLOT_COMMIT,
        SLOT_KILL,
        SLOT_FREE
    } slot_act_e;

    // Tags are zero-extended to EXT_W; bit iw holds the wrap flag.
    function automatic logic tag_older(input logic [EXT_W-1:0] a,
                                       input logic [EXT_W-1:0] b,
                                       input int unsigned      iw);
        logic [EXT_W-1:0] mask;
        logic [EXT_W-1:0] ai;
        logic [EXT_W-1:0] bi;
        mask = ({{MAX_IDX_W{1'b0}}, 1'b1} << iw) - {{MAX_IDX_W{1'b0}}, 1'b1};
        ai   = a & mask;
        bi   = b & mask;
        if (a[iw] == b[iw]) return ai < bi;
        return ai > bi;
    endfunction

endpackage

// File: rtl/ssb_slot.sv
module ssb_slot
    import ssb_pkg::*;
#(
    parameter int unsigned ADDR_W = DEF_ADDR_W,
    parameter int unsigned DATA_W = DEF_DATA_W,
    parameter int unsigned TAG_W  = DEF_ROB_IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  slot_act_e         act,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic [DATA_W-1:0] fill_data,
    input  logic [TAG_W-1:0]  fill_tag,
    output logic              vld,
    output logic              spec,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] data,
    output logic [TAG_W-1:0]  tag
);

    always_ff @(posedge clk) begin
        if (rst) begin
            vld  <= 1'b0;
            spec <= 1'b0;
        end else begin
            case (act)
                SLOT_FILL: begin
                    vld  <= 1'b1;
                    spec <= 1'b1;
                end
                SLOT_COMMIT: spec <= 1'b0;
                SLOT_KILL: begin
                    vld  <= 1'b0;
                    spec <= 1'b0;
                end
                SLOT_FREE: vld <= 1'b0;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (act == SLOT_FILL) begin
            addr <= fill_addr;
            data <= fill_data;
            tag  <= fill_tag;
        end
    end

    AST_FILL_EMPTY: assert property (@(posedge clk) disable iff (rst)
        act == SLOT_FILL |-> !vld); // R2
    AST_COMMIT_SPEC: assert property (@(posedge clk) disable iff (rst)
        act == SLOT_COMMIT |-> (vld && spec)); // R4
    AST_FREE_COMMITTED: assert property (@(posedge clk) disable iff (rst)
        act == SLOT_FREE |-> (vld && !spec)); // R6
    AST_COMMITTED_KEPT: assert property (@(posedge clk) disable iff (rst)
        (vld && !spec && act != SLOT_FREE) |=> (vld && !spec && $stable(data))); // R5

endmodule

// File: rtl/ssb_oldest.sv
module ssb_oldest
    import ssb_pkg::*;
#(
    parameter int unsigned ENTRIES   = DEF_ENTRIES,
    parameter int unsigned ROB_IDX_W = DEF_ROB_IDX_W,
    localparam int unsigned TAG_W    = ROB_IDX_W + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ENTRIES-1:0] vld,
    input  logic [TAG_W-1:0]   tag [ENTRIES],
    output logic [ENTRIES-1:0] pick
);

    for (genvar i = 0; i < ENTRIES; i++) begin : g_pick
        always_comb begin
            pick[i] = vld[i];
            for (int j = 0; j < ENTRIES; j++) begin
                if (j != i && vld[j] &&
                    tag_older(EXT_W'(tag[j]), EXT_W'(tag[i]), ROB_IDX_W))
                    pick[i] = 1'b0;
            end
        end
    end

    AST_OLDEST_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(pick)); // R6
    AST_OLDEST_PRESENT: assert property (@(posedge clk) disable iff (rst)
        (|vld) |-> (|pick)); // R6

endmodule

// File: rtl/ssb_fwd.sv
module ssb_fwd
    import ssb_pkg::*;
#(
    parameter int unsigned ENTRIES   = DEF_ENTRIES,
    parameter int unsigned ADDR_W    = DEF_ADDR_W,
    parameter int unsigned ROB_IDX_W = DEF_ROB_IDX_W,
    localparam int unsigned TAG_W    = ROB_IDX_W + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ld_valid,
    input  logic [ADDR_W-1:0]  ld_addr,
    input  logic [TAG_W-1:0]   ld_tag,
    input  logic [ENTRIES-1:0] vld,
    input  logic [ADDR_W-1:0]  addr [ENTRIES],
    input  logic [TAG_W-1:0]   tag  [ENTRIES],
    output logic               hit,
    output logic [ENTRIES-1:0] sel
);

    logic [ENTRIES-1:0] cand;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_cand
        assign cand[i] = ld_valid && vld[i] && (addr[i] == ld_addr) &&
                         tag_older(EXT_W'(tag[i]), EXT_W'(ld_tag), ROB_IDX_W);
    end

    // Keep the candidate that no other candidate is younger than.
    for (genvar i = 0; i < ENTRIES; i++) begin : g_sel
        always_comb begin
            sel[i] = cand[i];
            for (int j = 0; j < ENTRIES; j++) begin
                if (j != i && cand[j] &&
                    tag_older(EXT_W'(tag[i]), EXT_W'(tag[j]), ROB_IDX_W))
                    sel[i] = 1'b0;
            end
        end
    end

    assign hit = |cand;

    AST_FWD_SINGLE: assert property (@(posedge clk) disable iff (rst)
        hit |-> ($countones(sel) == 1)); // R7
    AST_FWD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !ld_valid |-> (!hit && sel == '0)); // R7

endmodule

// File: rtl/spec_store_buf.sv
module spec_store_buf
    import ssb_pkg::*;
#(
    parameter int unsigned ENTRIES   = DEF_ENTRIES,
    parameter int unsigned ADDR_W    = DEF_ADDR_W,
    parameter int unsigned DATA_W    = DEF_DATA_W,
    parameter int unsigned ROB_IDX_W = DEF_ROB_IDX_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 st_valid,
    output logic                 st_ready,
    input  logic [ADDR_W-1:0]    st_addr,
    input  logic [DATA_W-1:0]    st_data,
    input  logic [ROB_IDX_W:0]   st_tag,
    input  logic                 cm_valid,
    input  logic [ROB_IDX_W:0]   cm_tag,
    input  logic                 ab_valid,
    input  logic [ROB_IDX_W:0]   ab_tag,
    output logic                 dr_valid,
    input  logic                 dr_ready,
    output logic [ADDR_W-1:0]    dr_addr,
    output logic [DATA_W-1:0]    dr_data,
    input  logic                 ld_valid,
    input  logic [ADDR_W-1:0]    ld_addr,
    input  logic [ROB_IDX_W:0]   ld_tag,
    input  logic [DATA_W-1:0]    ld_cache_data,
    output logic                 ld_hit,
    output logic [DATA_W-1:0]    ld_data
);

    localparam int unsigned TAG_W = ROB_IDX_W + 1;

    logic [ENTRIES-1:0] vld;
    logic [ENTRIES-1:0] spec;
    logic [ADDR_W-1:0]  s_addr [ENTRIES];
    logic [DATA_W-1:0]  s_data [ENTRIES];
    logic [TAG_W-1:0]   s_tag  [ENTRIES];

    logic [ENTRIES-1:0] fill_oh;
    logic [ENTRIES-1:0] oldest;
    logic [ENTRIES-1:0] fwd_sel;
    logic               st_fire;
    logic               dr_fire;
    logic [DATA_W-1:0]  fwd_data;

    // Lowest free slot takes the next store.
    always_comb begin
        logic found;
        fill_oh = '0;
        found   = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (!vld[i] && !found) begin
                fill_oh[i] = 1'b1;
                found      = 1'b1;
            end
        end
    end

    assign st_ready = ~&vld;
    assign st_fire  = st_valid && st_ready;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
        slot_act_e act;
        logic      kill;
        logic      cm_hit;

        assign kill   = ab_valid && vld[i] && spec[i] &&
                        !tag_older(EXT_W'(s_tag[i]), EXT_W'(ab_tag), ROB_IDX_W);
        assign cm_hit = cm_valid && vld[i] && spec[i] && (s_tag[i] == cm_tag);

        always_comb begin
            if (st_fire && fill_oh[i])   act = SLOT_FILL;
            else if (kill)               act = SLOT_KILL;
            else if (cm_hit)             act = SLOT_COMMIT;
            else if (dr_fire && oldest[i]) act = SLOT_FREE;
            else                         act = SLOT_HOLD;
        end

        ssb_slot #(
            .ADDR_W (ADDR_W),
            .DATA_W (DATA_W),
            .TAG_W  (TAG_W)
        ) u_slot (
            .clk       (clk),
            .rst       (rst),
            .act       (act),
            .fill_addr (st_addr),
            .fill_data (st_data),
            .fill_tag  (st_tag),
            .vld       (vld[i]),
            .spec      (spec[i]),
            .addr      (s_addr[i]),
            .data      (s_data[i]),
            .tag       (s_tag[i])
        );
    end

    ssb_oldest #(
        .ENTRIES   (ENTRIES),
        .ROB_IDX_W (ROB_IDX_W)
    ) u_oldest (
        .clk  (clk),
        .rst  (rst),
        .vld  (vld),
        .tag  (s_tag),
        .pick (oldest)
    );

    ssb_fwd #(
        .ENTRIES   (ENTRIES),
        .ADDR_W    (ADDR_W),
        .ROB_IDX_W (ROB_IDX_W)
    ) u_fwd (
        .clk      (clk),
        .rst      (rst),
        .ld_valid (ld_valid),
        .ld_addr  (ld_addr),
        .ld_tag   (ld_tag),
        .vld      (vld),
        .addr     (s_addr),
        .tag      (s_tag),
        .hit      (ld_hit),
        .sel      (fwd_sel)
    );

    // Drain offers the oldest slot only once it is committed.
    assign dr_valid = |(oldest & ~spec);
    assign dr_fire  = dr_valid && dr_ready;

    always_comb begin
        dr_addr  = '0;
        dr_data  = '0;
        fwd_data = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (oldest[i]) begin
                dr_addr = dr_addr | s_addr[i];
                dr_data = dr_data | s_data[i];
            end
            if (fwd_sel[i]) fwd_data = fwd_data | s_data[i];
        end
    end

    assign ld_data = ld_hit ? fwd_data : ld_cache_data;

    AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (st_valid && !st_ready) |=> ($countones(vld) <= $past($countones(vld)))); // R3
    AST_DRAIN_SHRINKS: assert property (@(posedge clk) disable iff (rst)
        (dr_fire && !st_fire) |=> ($countones(vld) < $past($countones(vld)))); // R6
    AST_ABORT_NO_SPEC_LEFT: assert property (@(posedge clk) disable iff (rst)
        (ab_valid && !st_fire && !cm_valid && $countones(vld & spec) != 0) |=>
        ($countones(vld & spec) <= $past($countones(vld & spec)))); // R5

endmodule

// File: tb/spec_store_buf_bench.sv
`timescale 1ns/1ps
module spec_store_buf_bench;

    localparam int N  = 4;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int IW = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic          st_valid, st_ready;
    logic [AW-1:0] st_addr;
    logic [DW-1:0] st_data;
    logic [IW:0]   st_tag;
    logic          cm_valid;
    logic [IW:0]   cm_tag;
    logic          ab_valid;
    logic [IW:0]   ab_tag;
    logic          dr_valid, dr_ready;
    logic [AW-1:0] dr_addr;
    logic [DW-1:0] dr_data;
    logic          ld_valid;
    logic [AW-1:0] ld_addr;
    logic [IW:0]   ld_tag;
    logic [DW-1:0] ld_cache_data;
    logic          ld_hit;
    logic [DW-1:0] ld_data;

    int n_checks = 0;
    int n_errors = 0;

    bit            mv [N];
    bit            ms [N];
    logic [AW-1:0] ma [N];
    logic [DW-1:0] md [N];
    logic [IW:0]   mt [N];

    always #2.5 clk = ~clk;

    spec_store_buf u_spec_store_buf (
        .clk(clk), .rst(rst),
        .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr),
        .st_data(st_data), .st_tag(st_tag),
        .cm_valid(cm_valid), .cm_tag(cm_tag),
        .ab_valid(ab_valid), .ab_tag(ab_tag),
        .dr_valid(dr_valid), .dr_ready(dr_ready), .dr_addr(dr_addr), .dr_data(dr_data),
        .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_tag(ld_tag),
        .ld_cache_data(ld_cache_data), .ld_hit(ld_hit), .ld_data(ld_data)
    );

    // R9: equal wrap bits -> smaller index older; different -> larger index older.
    function automatic bit older(input logic [IW:0] a, input logic [IW:0] b);
        if (a[IW] == b[IW]) return a[IW-1:0] < b[IW-1:0];
        return a[IW-1:0] > b[IW-1:0];
    endfunction

    task automatic chk(input bit ok, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic idle();
        st_valid = 0; st_addr = '0; st_data = '0; st_tag = '0;
        cm_valid = 0; cm_tag = '0; ab_valid = 0; ab_tag = '0;
        dr_ready = 0; ld_valid = 0; ld_addr = '0; ld_tag = '0; ld_cache_data = '0;
    endtask

    // Compare all outputs with the model, apply this cycle's effect, advance.
    task automatic step();
        bit full;
        int o, y, f;
        bit e_dv;
        logic [DW-1:0] e_ld;
        #1;
        full = 1;
        for (int i = 0; i < N; i++) if (!mv[i]) full = 0;
        chk(st_ready == !full, "R3 st_ready", DW'(st_ready), DW'(!full));
        o = -1;
        for (int i = 0; i < N; i++)
            if (mv[i] && (o < 0 || older(mt[i], mt[o]))) o = i;
        e_dv = (o >= 0) && !ms[o];
        chk(dr_valid == e_dv, "R6 dr_valid", DW'(dr_valid), DW'(e_dv));
        if (e_dv) begin
            chk(dr_addr == ma[o], "R6 dr_addr", DW'(dr_addr), DW'(ma[o]));
            chk(dr_data == md[o], "R6 dr_data", dr_data, md[o]);
        end
        y = -1;
        if (ld_valid)
            for (int i = 0; i < N; i++)
                if (mv[i] && ma[i] == ld_addr && older(mt[i], ld_tag) &&
                    (y < 0 || older(mt[y], mt[i]))) y = i;
        chk(ld_hit == (y >= 0), "R7 ld_hit", DW'(ld_hit), DW'(y >= 0));
        e_ld = (y >= 0) ? md[y] : ld_cache_data;
        chk(ld_data == e_ld, "R8 ld_data", ld_data, e_ld);
        f = -1;
        for (int i = 0; i < N; i++) if (!mv[i] && f < 0) f = i;
        if (ab_valid)
            for (int i = 0; i < N; i++)
                if (mv[i] && ms[i] && !older(mt[i], ab_tag)) begin mv[i] = 0; ms[i] = 0; end
        if (cm_valid)
            for (int i = 0; i < N; i++)
                if (mv[i] && ms[i] && mt[i] == cm_tag) ms[i] = 0;
        if (e_dv && dr_ready) mv[o] = 0;
        if (st_valid && !full) begin
            mv[f] = 1; ms[f] = 1; ma[f] = st_addr; md[f] = st_data; mt[f] = st_tag;
        end
        @(posedge clk);
        #1;
    endtask

    task automatic store(input logic [IW:0] t, input logic [AW-1:0] a, input logic [DW-1:0] d);
        idle(); st_valid = 1; st_tag = t; st_addr = a; st_data = d; step(); idle();
    endtask

    task automatic load(input logic [IW:0] t, input logic [AW-1:0] a, input logic [DW-1:0] c);
        ld_valid = 1; ld_tag = t; ld_addr = a; ld_cache_data = c; #1;
    endtask

    initial begin
        #(200000 * 5);
        n_errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        logic [IW:0] next_tag;
        void'($urandom(32'h5eed_0c1a));
        idle();
        for (int i = 0; i < N; i++) begin mv[i] = 0; ms[i] = 0; end
        rst = 1;
        repeat (3) @(posedge clk);
        #1 rst = 0;

        // R1 reset state
        load(5'd3, 16'h10, 32'h0);
        chk(st_ready === 1'b1, "R1 st_ready", DW'(st_ready), 1);
        chk(dr_valid === 1'b0, "R1 dr_valid", DW'(dr_valid), 0);
        chk(ld_hit === 1'b0, "R1 ld_hit", DW'(ld_hit), 0);
        step(); idle();

        // R2 store then forward; speculative store does not drain
        store(5'd2, 16'h10, 32'hAAAA_0001);
        load(5'd3, 16'h10, 32'hC0C0_C0C0);
        chk(ld_hit && ld_data == 32'hAAAA_0001, "R2 forward", ld_data, 32'hAAAA_0001);
        chk(!dr_valid, "R2 spec not drained", DW'(dr_valid), 0);
        load(5'd2, 16'h10, 32'hC0C0_C0C0);
        chk(ld_data == 32'hC0C0_C0C0, "R8 equal tag reads cache", ld_data, 32'hC0C0_C0C0);
        step(); idle();

        // R7 youngest older match
        store(5'd4, 16'h10, 32'hBBBB_0002);
        load(5'd5, 16'h10, 32'h0);
        chk(ld_data == 32'hBBBB_0002, "R7 youngest older", ld_data, 32'hBBBB_0002);
        load(5'd3, 16'h10, 32'h0);
        chk(ld_data == 32'hAAAA_0001, "R7 skip younger store", ld_data, 32'hAAAA_0001);
        step(); idle();

        // R4 commit makes it drainable; R10 still forwards
        cm_valid = 1; cm_tag = 5'd2; step(); idle();
        #1;
        chk(dr_valid && dr_data == 32'hAAAA_0001, "R4 commit drains", dr_data, 32'hAAAA_0001);
        load(5'd3, 16'h10, 32'h0);
        chk(ld_hit && ld_data == 32'hAAAA_0001, "R10 committed forwards", ld_data, 32'hAAAA_0001);
        step(); idle();

        // R3 full buffer drops store
        store(5'd6, 16'h20, 32'hCCCC_0003);
        store(5'd7, 16'h20, 32'hDDDD_0004);
        #1;
        chk(!st_ready, "R3 full not ready", DW'(st_ready), 0);
        store(5'd8, 16'h30, 32'hEEEE_0005);

        // R5 abort from tag 6
        ab_valid = 1; ab_tag = 5'd6; step(); idle();
        load(5'd9, 16'h20, 32'h1234);
        chk(!ld_hit && ld_data == 32'h1234, "R5 squashed gone", ld_data, 32'h1234);
        load(5'd9, 16'h10, 32'h1234);
        chk(ld_data == 32'hBBBB_0002, "R5 older spec kept", ld_data, 32'hBBBB_0002);
        load(5'd9, 16'h30, 32'h5678);
        chk(!ld_hit, "R3 dropped store invisible", DW'(ld_hit), 0);
        step(); idle();

        // R6 drain order: tag 2 leaves, tag 4 waits until committed
        dr_ready = 1; step(); idle();
        #1;
        chk(!dr_valid, "R6 spec oldest blocks", DW'(dr_valid), 0);
        cm_valid = 1; cm_tag = 5'd4; step(); idle();
        #1;
        chk(dr_valid && dr_data == 32'hBBBB_0002, "R6 second drain", dr_data, 32'hBBBB_0002);
        dr_ready = 1; step(); idle();
        load(5'd9, 16'h10, 32'h0);
        chk(!ld_hit && !dr_valid, "R6 empty after drain", DW'(ld_hit), 0);
        step(); idle();

        // R9 wrap: tag 14 (wrap 0) older than 16/17 (wrap 1)
        store(5'd14, 16'h40, 32'h7777_0007);
        store(5'd17, 16'h40, 32'h8888_0008);
        load(5'd16, 16'h40, 32'h0);
        chk(ld_data == 32'h7777_0007, "R9 wrap older", ld_data, 32'h7777_0007);
        load(5'd19, 16'h40, 32'h0);
        chk(ld_data == 32'h8888_0008, "R9 wrap youngest", ld_data, 32'h8888_0008);
        step(); idle();
        cm_valid = 1; cm_tag = 5'd14; step(); idle();
        cm_valid = 1; cm_tag = 5'd17; step(); idle();
        #1;
        chk(dr_data == 32'h7777_0007, "R9 drain order across wrap", dr_data, 32'h7777_0007);
        dr_ready = 1; step(); idle();
        #1;
        chk(dr_data == 32'h8888_0008, "R9 drain second", dr_data, 32'h8888_0008);
        dr_ready = 1; step(); idle();

        // Random phase
        next_tag = 5'd20;
        for (int c = 0; c < 4000; c++) begin
            bit full;
            int so, nsp;
            idle();
            full = 1;
            for (int i = 0; i < N; i++) if (!mv[i]) full = 0;
            if ($urandom_range(1, 0) == 1) begin
                st_valid = 1; st_tag = next_tag;
                st_addr = AW'($urandom_range(3, 0) * 4);
                st_data = $urandom();
                if (!full) next_tag = next_tag + IW'($urandom_range(2, 1));
            end
            so = -1; nsp = 0;
            for (int i = 0; i < N; i++)
                if (mv[i] && ms[i]) begin
                    nsp++;
                    if (so < 0 || older(mt[i], mt[so])) so = i;
                end
            if (so >= 0 && $urandom_range(9, 0) < 3) begin
                cm_valid = 1; cm_tag = mt[so];
            end else if (so >= 0 && $urandom_range(19, 0) == 0) begin
                int pick = $urandom_range(N - 1, 0);
                for (int k = 0; k < N; k++) begin
                    int idx = (pick + k) % N;
                    if (!ab_valid && mv[idx] && ms[idx]) begin
                        ab_valid = 1; ab_tag = mt[idx];
                    end
                end
            end
            dr_ready = ($urandom_range(9, 0) < 6);
            ld_valid = ($urandom_range(3, 0) != 0);
            ld_tag   = next_tag - (IW + 1)'($urandom_range(3, 0));
            ld_addr  = AW'($urandom_range(3, 0) * 4);
            ld_cache_data = $urandom();
            step();
        end

        idle();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule